// File: doc/BRIEF.md
# Pipelined CORDIC I/Q Phase Rotator with Return Subtraction

This block sits in the digital part of a Cartesian feedback transmitter loop. It takes a digitized feedback sample pair and turns it through a phase-correction angle, which cancels the phase shift that the analog loop adds. It then subtracts the rotated pair from the reference I/Q pair, and the result is the predistorted return sample that drives the forward path.

The rotation uses shift-and-add micro-rotations in rotation mode, with no multipliers. Angles beyond a quarter turn are first folded: the vector is negated and the angle is moved by a half turn. The processing gain of the micro-rotations is removed by one constant shift-add scaling. Registers sit only after each group of micro-rotations. This keeps latency and flop count low while the combinational depth per cycle stays at a few adders. The reference pair and the valid strobe travel through a matching delay line, so the two operands of the subtraction stay aligned.

Top module: `iq_phase_rotator`

## Requirements
- R1: `valid_o` equals `valid_i` from exactly 5 clock cycles earlier (default parameters). A sample presented with `valid_i` low gives `valid_o` low in its output slot, and valid and idle samples may be freely interleaved.
- R2: For a valid sample with angle θ, the returns are `ret_re_o = ref_re − (fb_re·cosθ − fb_im·sinθ)` and `ret_im_o = ref_im − (fb_re·sinθ + fb_im·cosθ)`, each within 4 + 0.006·|fb| LSB.
- R3: `corr_phase_i` is 12-bit two's complement with an LSB of π/2048, so −2048 means −π and 2047 is one step below +π. Angles anywhere on the circle, including those beyond ±π/2, meet the R2 accuracy.
- R4: Extreme feedback vectors, for example (−2048, −2048) or (2047, 2047), combined with extreme reference values give correct returns without wrap-around. The returns are 14-bit two's complement.
- R5: While `rst_ni` is low, `valid_o` is 0 and both returns are 0.
- R6: Rotation preserves magnitude. The CORDIC gain is removed by a constant scaling of about 0.6073, so a feedback vector on an axis comes out at its original length, within the R2 tolerance.
- R7: Nine micro-rotations are applied, with a register after every group of three. The angle left over after the last micro-rotation stays within about 0.23°.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| fb_re_i | input | 12 | Feedback in-phase sample, signed |
| fb_im_i | input | 12 | Feedback quadrature sample, signed |
| corr_phase_i | input | 12 | Correction angle, signed, LSB = π/2048 |
| ref_re_i | input | 12 | Reference in-phase sample, signed |
| ref_im_i | input | 12 | Reference quadrature sample, signed |
| valid_o | output | 1 | Output sample strobe |
| ret_re_o | output | 14 | Return in-phase sample, signed |
| ret_im_o | output | 14 | Return quadrature sample, signed |

## Verification
The assertions check three things on every cycle. After the fold, the angle lies within a quarter turn. The angle left after the last group stays inside its convergence bound. The rotated vector and the returns stay inside their magnitude limits. Only the bench's scenarios can show the arithmetic accuracy against true sine and cosine, the five-cycle alignment of the strobe with gaps in the stream, and the reset values. It does this by sweeping all 4096 angles against a set of axis, corner and small vectors.

// File: rtl/iq_rot_pkg.sv
package iq_rot_pkg;

  // atan(2^-i) in units of pi/65536
  function automatic int atan_hp(input int i);
    case (i)
      0: return 16384;
      1: return 9672;
      2: return 5110;
      3: return 2594;
      4: return 1302;
      5: return 652;
      6: return 326;
      7: return 163;
      8: return 81;
      default: return 20861 >> i;
    endcase
  endfunction

  // same constant rounded to units of pi/2^frac (frac <= 16)
  function automatic int atan_c(input int i, input int frac);
    int sh;
    sh = 16 - frac;
    if (sh <= 0) return atan_hp(i);
    return (atan_hp(i) + (1 << (sh - 1))) >> sh;
  endfunction

endpackage

// File: rtl/iq_rot_micro.sv
module iq_rot_micro #(
  parameter int IDX  = 0,
  parameter int W    = 18,
  parameter int ZW   = 16,
  parameter int ZFRC = 14
) (
  input  logic signed [W-1:0]  x_i,
  input  logic signed [W-1:0]  y_i,
  input  logic signed [ZW-1:0] z_i,
  output logic signed [W-1:0]  x_o,
  output logic signed [W-1:0]  y_o,
  output logic signed [ZW-1:0] z_o
);
  localparam logic signed [ZW-1:0] STEP = ZW'(iq_rot_pkg::atan_c(IDX, ZFRC));

  logic signed [W-1:0] xs, ys;
  logic                d_pos;

  assign d_pos = ~z_i[ZW-1];
  assign xs    = x_i >>> IDX;
  assign ys    = y_i >>> IDX;

  always_comb begin
    if (d_pos) begin
      x_o = x_i - ys;
      y_o = y_i + xs;
      z_o = z_i - STEP;
    end else begin
      x_o = x_i + ys;
      y_o = y_i - xs;
      z_o = z_i + STEP;
    end
  end
endmodule

// File: rtl/iq_rot_group.sv
module iq_rot_group #(
  parameter int FIRST = 0,
  parameter int CNT   = 3,
  parameter int W     = 18,
  parameter int ZW    = 16,
  parameter int ZFRC  = 14
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [W-1:0]  x_i,
  input  logic signed [W-1:0]  y_i,
  input  logic signed [ZW-1:0] z_i,
  output logic signed [W-1:0]  x_o,
  output logic signed [W-1:0]  y_o,
  output logic signed [ZW-1:0] z_o
);
  logic signed [W-1:0]  xc [CNT+1];
  logic signed [W-1:0]  yc [CNT+1];
  logic signed [ZW-1:0] zc [CNT+1];

  assign xc[0] = x_i;
  assign yc[0] = y_i;
  assign zc[0] = z_i;

  for (genvar s = 0; s < CNT; s++) begin : g_stage
    iq_rot_micro #(.IDX(FIRST + s), .W(W), .ZW(ZW), .ZFRC(ZFRC)) u_micro (
      .x_i(xc[s]),   .y_i(yc[s]),   .z_i(zc[s]),
      .x_o(xc[s+1]), .y_o(yc[s+1]), .z_o(zc[s+1])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_o <= '0;
      y_o <= '0;
      z_o <= '0;
    end else begin
      x_o <= xc[CNT];
      y_o <= yc[CNT];
      z_o <= zc[CNT];
    end
  end
endmodule

// File: rtl/iq_rot_delay.sv
module iq_rot_delay #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 25
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  if (DEPTH == 0) begin : g_bypass
    assign q_o = d_i;
  end else begin : g_regs
    logic [WIDTH-1:0] sr [DEPTH];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int k = 0; k < DEPTH; k++) sr[k] <= '0;
      end else begin
        sr[0] <= d_i;
        for (int k = 1; k < DEPTH; k++) sr[k] <= sr[k-1];
      end
    end
    assign q_o = sr[DEPTH-1];
  end
endmodule

// File: rtl/iq_rot_gain.sv
module iq_rot_gain #(
  parameter int W  = 18,
  parameter int FB = 3,
  parameter int RW = 13
) (
  input  logic signed [W-1:0]  v_i,
  output logic signed [RW-1:0] r_o
);
  localparam logic signed [W-1:0] RND = W'(1 << (FB - 1));

  logic signed [W-1:0] scaled;

  // 0.6073 ~= 2^-1 + 2^-3 - 2^-6 - 2^-9 - 2^-13
  assign scaled = (v_i >>> 1) + (v_i >>> 3) - (v_i >>> 6) - (v_i >>> 9) - (v_i >>> 13);
  assign r_o    = RW'((scaled + RND) >>> FB);
endmodule

// File: rtl/iq_phase_rotator.sv
module iq_phase_rotator #(
  parameter int DW    = 12,
  parameter int AW    = 12,
  parameter int NITER = 9,
  parameter int GRP   = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [DW-1:0] fb_re_i,
  input  logic signed [DW-1:0] fb_im_i,
  input  logic signed [AW-1:0] corr_phase_i,
  input  logic signed [DW-1:0] ref_re_i,
  input  logic signed [DW-1:0] ref_im_i,
  output logic                 valid_o,
  output logic signed [DW+1:0] ret_re_o,
  output logic signed [DW+1:0] ret_im_o
);
  localparam int FB    = 3;
  localparam int ZF    = 3;
  localparam int W     = DW + 3 + FB;
  localparam int ZW    = AW + ZF + 1;
  localparam int ZFRC  = AW - 1 + ZF;
  localparam int NGRP  = (NITER + GRP - 1) / GRP;
  localparam int RW    = DW + 1;
  localparam int OW    = DW + 2;
  localparam int DLY_W = 2 * DW + 1;

  localparam logic signed [ZW-1:0] Z_PI   = ZW'(1 << ZFRC);
  localparam logic signed [ZW-1:0] Z_HALF = ZW'(1 << (ZFRC - 1));
  localparam logic signed [ZW-1:0] Z_RES  = ZW'(iq_rot_pkg::atan_c(NITER - 1, ZFRC) + NITER);
  localparam logic signed [RW-1:0] ROT_MAX = RW'(3 << (DW - 2));
  localparam logic signed [OW-1:0] RET_MAX = OW'(5 << (DW - 2));

  // ---------------- quadrant fold + input register ----------------
  logic signed [W-1:0]  x_in, y_in, x_f, y_f;
  logic signed [ZW-1:0] z_in, z_f;
  logic                 hi, lo;

  assign x_in = $signed({{(W-DW-FB){fb_re_i[DW-1]}}, fb_re_i, {FB{1'b0}}});
  assign y_in = $signed({{(W-DW-FB){fb_im_i[DW-1]}}, fb_im_i, {FB{1'b0}}});
  assign z_in = $signed({{(ZW-AW-ZF){corr_phase_i[AW-1]}}, corr_phase_i, {ZF{1'b0}}});
  assign hi   = z_in > Z_HALF;
  assign lo   = z_in < -Z_HALF;

  always_comb begin
    x_f = x_in;
    y_f = y_in;
    z_f = z_in;
    if (hi || lo) begin
      x_f = -x_in;
      y_f = -y_in;
      z_f = hi ? z_in - Z_PI : z_in + Z_PI;
    end
  end

  logic signed [W-1:0]  gx [NGRP+1];
  logic signed [W-1:0]  gy [NGRP+1];
  logic signed [ZW-1:0] gz [NGRP+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gx[0] <= '0;
      gy[0] <= '0;
      gz[0] <= '0;
    end else begin
      gx[0] <= x_f;
      gy[0] <= y_f;
      gz[0] <= z_f;
    end
  end

  assert_fold_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gz[0] <= Z_HALF) && (gz[0] >= -Z_HALF));

  // ---------------- grouped micro-rotations ----------------
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int FIRST = g * GRP;
    localparam int CNT   = (NITER - FIRST < GRP) ? NITER - FIRST : GRP;
    iq_rot_group #(.FIRST(FIRST), .CNT(CNT), .W(W), .ZW(ZW), .ZFRC(ZFRC)) u_grp (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .x_i   (gx[g]),   .y_i(gy[g]),   .z_i(gz[g]),
      .x_o   (gx[g+1]), .y_o(gy[g+1]), .z_o(gz[g+1])
    );
  end

  assert_residual_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gz[NGRP] <= Z_RES) && (gz[NGRP] >= -Z_RES));

  // ---------------- operand alignment ----------------
  logic [DLY_W-1:0] dly_q;
  logic             vld_d;
  logic signed [DW-1:0] ref_re_d, ref_im_d;

  iq_rot_delay #(.DEPTH(NGRP + 1), .WIDTH(DLY_W)) u_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({valid_i, ref_re_i, ref_im_i}),
    .q_o   (dly_q)
  );

  assign vld_d    = dly_q[DLY_W-1];
  assign ref_re_d = $signed(dly_q[2*DW-1:DW]);
  assign ref_im_d = $signed(dly_q[DW-1:0]);

  // ---------------- gain compensation + return subtraction ----------------
  logic signed [RW-1:0] rot_re, rot_im;
  logic signed [OW-1:0] sum_re, sum_im;

  iq_rot_gain #(.W(W), .FB(FB), .RW(RW)) u_gain_re (.v_i(gx[NGRP]), .r_o(rot_re));
  iq_rot_gain #(.W(W), .FB(FB), .RW(RW)) u_gain_im (.v_i(gy[NGRP]), .r_o(rot_im));

  assert_rot_mag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_d |-> (rot_re <= ROT_MAX) && (rot_re >= -ROT_MAX) &&
              (rot_im <= ROT_MAX) && (rot_im >= -ROT_MAX));

  // two's complement of the rotated operand, then add
  assign sum_re = OW'(ref_re_d) + (~OW'(rot_re)) + OW'(1);
  assign sum_im = OW'(ref_im_d) + (~OW'(rot_im)) + OW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      ret_re_o <= '0;
      ret_im_o <= '0;
    end else begin
      valid_o  <= vld_d;
      ret_re_o <= sum_re;
      ret_im_o <= sum_im;
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (ret_re_o <= RET_MAX) && (ret_re_o >= -RET_MAX) &&
                (ret_im_o <= RET_MAX) && (ret_im_o >= -RET_MAX));
endmodule

// File: tb/iq_phase_rotator_tb.sv
module iq_phase_rotator_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 5;
  localparam int NANG       = 4096;
  localparam int NVEC       = 8;
  localparam real PI        = 3.14159265358979;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid;
  logic signed [11:0] fb_re, fb_im, ph, ref_re, ref_im;
  logic valid_o;
  logic signed [13:0] ret_re, ret_im;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  int    e_re [8];
  int    e_im [8];
  int    e_tol[8];
  bit    e_v  [8];
  string e_tag[8];

  always #(CLK_PERIOD/2) clk = ~clk;

  iq_phase_rotator dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid),
    .fb_re_i(fb_re), .fb_im_i(fb_im), .corr_phase_i(ph),
    .ref_re_i(ref_re), .ref_im_i(ref_im),
    .valid_o(valid_o), .ret_re_o(ret_re), .ret_im_o(ret_im)
  );

  task automatic chk(input string req, input int act, input int exp, input int tol);
    int diff;
    n_chk++;
    diff = act - exp;
    if (diff < 0) diff = -diff;
    if (diff > tol) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (tol %0d)", req, act, exp, tol);
    end
  endtask

  function automatic int vec_re(input int v);
    case (v)
      0: return 2047;  1: return 0;     2: return -2048; 3: return 2047;
      4: return -2048; 5: return 1000;  6: return 1;     default: return 0;
    endcase
  endfunction

  function automatic int vec_im(input int v);
    case (v)
      0: return 0;     1: return 2047;  2: return -2048; 3: return 2047;
      4: return 2047;  5: return -1500; 6: return 0;     default: return 0;
    endcase
  endfunction

  task automatic check_slot(input int slot);
    chk("R1 valid alignment", int'(valid_o), int'(e_v[slot]), 0);
    if (e_v[slot]) begin
      chk(e_tag[slot], int'(ret_re), e_re[slot], e_tol[slot]);
      chk(e_tag[slot], int'(ret_im), e_im[slot], e_tol[slot]);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    valid = 1'b0; fb_re = '0; fb_im = '0; ph = '0; ref_re = '0; ref_im = '0;
    for (int s = 0; s < 8; s++) begin
      e_v[s] = 1'b0; e_re[s] = 0; e_im[s] = 0; e_tol[s] = 0; e_tag[s] = "R1";
    end
    repeat (3) @(negedge clk);
    // R5: reset state
    chk("R5 reset valid", int'(valid_o), 0, 0);
    chk("R5 reset re", int'(ret_re), 0, 0);
    chk("R5 reset im", int'(ret_im), 0, 0);
    rst_n = 1'b1;

    for (int k = 0; k < NVEC * NANG + LAT; k++) begin
      @(negedge clk);
      if (k >= LAT) check_slot((k - LAT) % 8);
      if (k < NVEC * NANG) begin
        int  vi, a, fr, fi, rr, ri;
        real th, xr, yr, mag;
        bit  v;
        vi = k / NANG;
        a  = (k % NANG) - 2048;
        fr = vec_re(vi);
        fi = vec_im(vi);
        rr = ((k * 37) % 4096) - 2048;
        ri = 2047 - ((k * 53) % 4096);
        v  = (k % 7) != 3;
        valid = v; fb_re = 12'(fr); fb_im = 12'(fi); ph = 12'(a);
        ref_re = 12'(rr); ref_im = 12'(ri);
        th  = a * PI / 2048.0;
        xr  = fr * $cos(th) - fi * $sin(th);
        yr  = fr * $sin(th) + fi * $cos(th);
        mag = $sqrt(real'(fr) * fr + real'(fi) * fi);
        e_v  [k % 8] = v;
        e_re [k % 8] = int'(rr - xr);
        e_im [k % 8] = int'(ri - yr);
        e_tol[k % 8] = 4 + int'(0.006 * mag);
        if (vi >= 2 && vi <= 4)        e_tag[k % 8] = "R4 extreme vector";
        else if (vi <= 1)              e_tag[k % 8] = "R6 axis magnitude";
        else if (a > 1024 || a < -1024) e_tag[k % 8] = "R3 wide angle";
        else                           e_tag[k % 8] = "R2 rotation accuracy";
      end else begin
        valid = 1'b0;
        e_v[k % 8] = 1'b0;
      end
    end
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule